// File: doc/BRIEF.md
# Range Cache Maintenance Engine

This block walks a physical address range and issues one clean-and-invalidate request to a cache tag interface for every 128-byte granule that the range touches. Software writes a 64-bit start address and a 64-bit length through four 32-bit registers. The length holds the size minus one, so the last byte is part of the range. Software then writes a control word that sets the enable bit, selects range mode and picks the operation type. The engine clears the enable bit when the walk is over, and software polls that bit to learn that the operation has finished.

Each instance owns one window of the address space, set by parameters. Inside the walk, a granule outside that window produces no request and costs one cycle. A granule inside the window raises a request and waits for the cache to acknowledge it. A line that is absent from the cache is resolved by the cache itself, which still acknowledges. Skipped granules never count as errors, so every operation ends with success.

Top module: `range_maint_engine`

## Requirements
- R1: After reset all registers read 0, the control bit 0 reads 0 and no request is raised.
- R2: The start address low and high words at offsets 0x5008 and 0x500C, and the length low and high words at 0x5010 and 0x5014, read back the last value written while the engine is idle.
- R3: Control at offset 0x5004 reads back bit 1 (range mode) and bits 3:2 (operation type) as written. Bit 0 reads 1 from the edge that accepts a valid start until the walk ends, and 0 afterwards.
- R4: A valid start is a write of 1 to bit 0 with bit 1 set and type 1 (clean and invalidate). It requests every owned granule from floor(start/128) up to and including floor((start+length)/128). The granules go out in ascending order, each exactly once, each carrying the granule's aligned byte address.
- R5: A granule whose aligned address lies outside the window from OWN_BASE to OWN_LIMIT (inclusive) produces no request. The walk still completes and returns bit 0 to 0.
- R6: A request holds valid with a stable address until the cycle in which the acknowledge is high. The next granule is taken up only after that cycle.
- R7: While bit 0 reads 1, writes to control and to the start and length words have no effect on their read values or on the ongoing walk.
- R8: A control write with bit 0 set but range mode clear, or with a type other than 1, finishes at once. Bit 0 reads 0 on the next read and no request is issued.
- R9: The end granule comes from a 65-bit sum. A range whose end lies past the top of the 64-bit space stops at the topmost granule and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr (combinational) |
| mreq_valid | output | 1 | Maintenance request to the cache tag interface |
| mreq_addr | output | 64 | 128-byte aligned address of the granule requested |
| mreq_ack | input | 1 | Cache acknowledge; completes the current request |

## Verification
The hardest case to reach from the ports is a range whose end sum carries out of 64 bits. Only a start in the last granules of the address space combined with a huge length gets there, and a wrapped end would leave the walker circling almost forever. Directed ranges at the very top of the space reach this case, and a per-operation cycle limit turns a runaway walk into a failure. Writes made while a request is being held back are the second hard case. The bench reaches it by withholding the acknowledge while it pokes the registers.

// File: rtl/range_maint_engine.sv
module range_maint_engine #(
  parameter int unsigned AW       = 64,
  parameter int unsigned GRAN_LG  = 7,
  parameter logic [63:0] OWN_BASE = 64'h0000_0000_0000_1000,
  parameter logic [63:0] OWN_LIMIT = 64'h0000_0000_0000_1FFF,
  parameter logic [15:0] OFS_CTRL = 16'h5004,
  parameter logic [15:0] OFS_SLO  = 16'h5008,
  parameter logic [15:0] OFS_SHI  = 16'h500C,
  parameter logic [15:0] OFS_LLO  = 16'h5010,
  parameter logic [15:0] OFS_LHI  = 16'h5014
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mreq_valid,
  output logic [63:0] mreq_addr,
  input  logic        mreq_ack
);
  localparam int unsigned GW = AW - GRAN_LG;
  localparam logic [1:0] TYPE_CLEAN_INV = 2'd1;

  logic [AW-1:0] start_q, len_q;
  logic          busy, op_range;
  logic [1:0]    op_type;
  logic [GW-1:0] cur_g, last_g;

  logic [AW:0]   end_sum;
  logic [GW-1:0] end_g;
  logic [AW-1:0] cur_addr;
  logic          ctl_hit, go, owned, step, at_end;

  assign ctl_hit  = reg_wr && !busy && (reg_addr == OFS_CTRL);
  assign go       = ctl_hit && reg_wdata[0] && reg_wdata[1] && (reg_wdata[3:2] == TYPE_CLEAN_INV);
  assign end_sum  = {1'b0, start_q} + {1'b0, len_q};
  assign end_g    = end_sum[AW] ? {GW{1'b1}} : end_sum[AW-1:GRAN_LG];
  assign cur_addr = {cur_g, {GRAN_LG{1'b0}}};
  assign owned    = (cur_addr >= OWN_BASE) && (cur_addr <= OWN_LIMIT);
  assign step     = busy && (!owned || mreq_ack);
  assign at_end   = (cur_g == last_g);

  assign mreq_valid = busy && owned;
  assign mreq_addr  = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= '0;
      len_q    <= '0;
      busy     <= 1'b0;
      op_range <= 1'b0;
      op_type  <= '0;
      cur_g    <= '0;
      last_g   <= '0;
    end else begin
      if (reg_wr && !busy) begin
        case (reg_addr)
          OFS_SLO: start_q[31:0]  <= reg_wdata;
          OFS_SHI: start_q[63:32] <= reg_wdata;
          OFS_LLO: len_q[31:0]    <= reg_wdata;
          OFS_LHI: len_q[63:32]   <= reg_wdata;
          default: ;
        endcase
      end
      if (ctl_hit) begin
        op_range <= reg_wdata[1];
        op_type  <= reg_wdata[3:2];
      end
      if (go) begin
        busy   <= 1'b1;
        cur_g  <= start_q[AW-1:GRAN_LG];
        last_g <= end_g;
      end else if (step) begin
        if (at_end) busy <= 1'b0;
        else        cur_g <= cur_g + 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = {28'd0, op_type, op_range, busy};
      OFS_SLO:  reg_rdata = start_q[31:0];
      OFS_SHI:  reg_rdata = start_q[63:32];
      OFS_LLO:  reg_rdata = len_q[31:0];
      OFS_LHI:  reg_rdata = len_q[63:32];
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/range_maint_engine_chk.sv
module range_maint_engine_chk #(
  parameter logic [63:0] OWN_BASE  = 64'h0000_0000_0000_1000,
  parameter logic [63:0] OWN_LIMIT = 64'h0000_0000_0000_1FFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        reg_wr,
  input logic [15:0] reg_addr,
  input logic [63:0] start_q,
  input logic [63:0] len_q,
  input logic        mreq_valid,
  input logic [63:0] mreq_addr,
  input logic        mreq_ack
);
  assert_req_needs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> busy);

  assert_req_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> (mreq_addr >= OWN_BASE) && (mreq_addr <= OWN_LIMIT));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ack |=> mreq_valid && $stable(mreq_addr));

  assert_req_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_ack |=> !mreq_valid || (mreq_addr > $past(mreq_addr)));

  assert_busy_regs_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && (reg_addr[15:4] == 12'h501 || reg_addr == 16'h5008 || reg_addr == 16'h500C)
    |=> $stable(start_q) && $stable(len_q));
endmodule

bind range_maint_engine range_maint_engine_chk #(.OWN_BASE(OWN_BASE), .OWN_LIMIT(OWN_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .start_q(start_q), .len_q(len_q), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr),
  .mreq_ack(mreq_ack));

// File: tb/range_maint_engine_tb_top.sv
`timescale 1ns/1ps
module range_maint_engine_tb_top;
  localparam logic [63:0] WB = 64'h1000;
  localparam logic [63:0] WL = 64'h1FFF;
  localparam logic [15:0] A_CTRL = 16'h5004, A_SLO = 16'h5008, A_SHI = 16'h500C,
                          A_LLO = 16'h5010, A_LHI = 16'h5014;

  logic clk = 0, rst_n = 0, reg_wr = 0, mreq_ack = 0;
  logic [15:0] reg_addr = A_CTRL;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic mreq_valid;
  logic [63:0] mreq_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  range_maint_engine #(.OWN_BASE(WB), .OWN_LIMIT(WL)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_ack(mreq_ack));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic longint exp_count(input logic [63:0] s, input logic [63:0] l, output logic [56:0] fg);
    logic [64:0] sm;
    logic [56:0] g0, g1, lo, hi;
    sm = {1'b0, s} + {1'b0, l};
    g0 = s[63:7];
    g1 = sm[64] ? {57{1'b1}} : sm[63:7];
    lo = (g0 > WB[63:7]) ? g0 : WB[63:7];
    hi = (g1 < WL[63:7]) ? g1 : WL[63:7];
    fg = lo;
    return (lo > hi) ? 0 : longint'(hi - lo) + 1;
  endfunction

  task automatic load(input logic [63:0] s, input logic [63:0] l);
    wr(A_SLO, s[31:0]); wr(A_SHI, s[63:32]);
    wr(A_LLO, l[31:0]); wr(A_LHI, l[63:32]);
  endtask

  task automatic serve(input logic [63:0] s, input logic [63:0] l, input string tag);
    logic [56:0] fg;
    longint cnt, seen;
    int cyc;
    logic [31:0] c;
    logic [63:0] a, ea;
    int d;
    cnt = exp_count(s, l, fg);
    seen = 0; cyc = 0;
    forever begin
      rd(A_CTRL, c);
      if (!c[0]) break;
      if (cyc > 5000) begin
        chk(0, {tag, " R9 walk did not end"}, 64'(cyc), 64'd5000);
        break;
      end
      if (mreq_valid) begin
        a = mreq_addr;
        ea = {fg + 57'(seen), 7'd0};
        chk(a == ea, {tag, " R4 request address"}, a, ea);
        d = $urandom % 4;
        for (int i = 0; i < d; i++) begin @(negedge clk); cyc++; end
        #1;
        chk(mreq_valid && mreq_addr == a, {tag, " R6 request held until ack"}, mreq_addr, a);
        mreq_ack = 1;
        @(negedge clk);
        mreq_ack = 0;
        seen++;
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
    chk(seen == cnt, {tag, " R4 R5 request count"}, 64'(seen), 64'(cnt));
  endtask

  task automatic run(input logic [63:0] s, input logic [63:0] l, input string tag);
    load(s, l);
    wr(A_CTRL, 32'h7);
    serve(s, l, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit quiet;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(A_CTRL, v); chk(v == 0, "R1 control after reset", v, 0);
    rd(A_SLO, v);  chk(v == 0, "R1 start after reset", v, 0);
    rd(A_LHI, v);  chk(v == 0, "R1 length after reset", v, 0);
    chk(!mreq_valid, "R1 no request after reset", mreq_valid, 0);

    wr(A_SLO, 32'h1111_2280); wr(A_SHI, 32'h3333_4444);
    wr(A_LLO, 32'h5555_6666); wr(A_LHI, 32'h7777_8888);
    rd(A_SLO, v); chk(v == 32'h1111_2280, "R2 start low", v, 32'h1111_2280);
    rd(A_SHI, v); chk(v == 32'h3333_4444, "R2 start high", v, 32'h3333_4444);
    rd(A_LLO, v); chk(v == 32'h5555_6666, "R2 length low", v, 32'h5555_6666);
    rd(A_LHI, v); chk(v == 32'h7777_8888, "R2 length high", v, 32'h7777_8888);

    load(64'h1000, 64'h7F);
    wr(A_CTRL, 32'h5);
    rd(A_CTRL, v); chk(v == 32'h4, "R8 range clear ends at once", v, 32'h4);
    wr(A_CTRL, 32'hB);
    rd(A_CTRL, v); chk(v == 32'hA, "R8 R3 type 2 ends at once", v, 32'hA);
    quiet = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (mreq_valid) quiet = 0; end
    chk(quiet, "R8 no request issued", !quiet, 0);

    load(64'h1010, 64'hFF);
    wr(A_CTRL, 32'h7);
    rd(A_CTRL, v); chk(v == 32'h7, "R3 busy with fields", v, 32'h7);
    serve(64'h1010, 64'hFF, "three granules");
    rd(A_CTRL, v); chk(v == 32'h6, "R3 enable clears at end", v, 32'h6);

    run(64'h107F, 64'h0, "single byte");
    run(64'h0F80, 64'h1FF, "lower edge R5");
    run(64'h1F80, 64'h17F, "upper edge R5");
    run(64'h4000, 64'h3FF, "unowned R5");

    load(64'h1000, 64'h17F);
    wr(A_CTRL, 32'h7);
    wr(A_SLO, 32'hABC0);
    wr(A_LLO, 32'h0);
    wr(A_CTRL, 32'h9);
    rd(A_SLO, v);  chk(v == 32'h1000, "R7 start frozen while busy", v, 32'h1000);
    rd(A_LLO, v);  chk(v == 32'h17F, "R7 length frozen while busy", v, 32'h17F);
    rd(A_CTRL, v); chk(v == 32'h7, "R7 control ignored while busy", v, 32'h7);
    serve(64'h1000, 64'h17F, "busy writes R7");

    run(64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FFFF, "top overflow R9");
    run(64'hFFFF_FFFF_FFFF_FF80, 64'h7F, "top exact R9");

    for (int n = 0; n < 40; n++) begin
      logic [63:0] s, l;
      s = 64'h800 + 64'($urandom % 32'h1C00);
      l = 64'($urandom % 32'h600);
      run(s, l, "random R4");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule